// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block predicts, once per cycle, where instruction fetch goes after the current 16-byte fetch line. The fetch address is split into a byte offset within the line (bits 3:0), a set index (bits 10:4) and a tag (bits 31:11). All ways of the indexed set are compared at once. Every way whose tag matches and whose stored branch offset is not below the fetch offset is a candidate. The candidate with the lowest offset among those predicted taken is reported, and the next fetch address follows from it.

Each entry keeps its own 4-bit local outcome history. A table of sixteen 2-bit counters is held for each set, and the entry's history picks one counter from its set's table. Histories are advanced speculatively at lookup time with the predicted outcome. The branch resolution logic later repairs the history with the real outcome, trains the counter, and allocates entries for taken branches that missed. Return targets come from a small circular return stack. Predicted calls push onto it and predicted returns pop from it.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every entry is invalid, so any lookup gives pr_hit=0 and pr_taken=0, with pr_next equal to the base of the following 16-byte line.
- R2: A way hits only when it is valid and its stored tag equals lk_addr[31:11], within the set selected by lk_addr[10:4]. A matching set index with a different tag is a miss.
- R3: A way whose stored offset is below lk_addr[3:0] is not a candidate. If no candidate remains, the result is a miss.
- R4: Among the candidates, the one with the lowest offset that is predicted taken is reported, with pr_taken=1. If no candidate is predicted taken, the lowest-offset candidate is reported with pr_hit=1 and pr_taken=0.
- R5: Branch kinds are encoded 00 conditional, 01 return, 10 call and 11 unconditional jump. Kinds 01, 10 and 11 are always predicted taken.
- R6: A conditional branch is predicted taken when bit 1 of the 2-bit counter of its set, indexed by the entry's history, is set. Counters reset to 01 and saturate at 00 and 11.
- R7: pr_next equals pr_target when pr_taken=1. Otherwise it is lk_addr with bits 3:0 cleared, plus 16.
- R8: On a lookup, each candidate whose offset is not above the reported taken branch shifts its predicted outcome into bit 0 of its history. When nothing is predicted taken, every candidate shifts.
- R9: An update that hits (same tag and offset) sets the entry's history to {up_hist[2:0], up_taken} and trains the counter selected by up_hist. It replaces the stored target when up_taken=1. If a lookup shifts the same entry's history in the same cycle, the update's value wins.
- R10: A taken update that misses allocates the way named by the set's replacement pointer, with history 0001. The pointer then advances by one, modulo 4. A not-taken update that misses changes no entry.
- R11: A predicted call pushes the base of the following line onto an 8-entry return stack. A predicted return takes its target from the top of the stack and pops it. The stack is circular, so a ninth push overwrites the oldest slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Fetch lookup request this cycle |
| lk_addr | input | 32 | Fetch address (line offset, set, tag) |
| pr_hit | output | 1 | At least one candidate branch in the line |
| pr_taken | output | 1 | Reported branch is predicted taken |
| pr_kind | output | 2 | Kind of the reported branch |
| pr_off | output | 4 | Offset of the reported branch within the line |
| pr_target | output | 32 | Predicted target (return stack top for returns) |
| pr_next | output | 32 | Next fetch address |
| pr_hist | output | 4 | History of the reported entry used for the prediction |
| up_valid | input | 1 | Resolved branch update this cycle |
| up_addr | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome |
| up_kind | input | 2 | Kind of the resolved branch (used on allocation) |
| up_target | input | 32 | Resolved target |
| up_hist | input | 4 | History snapshot the prediction used |

## Verification
The speculative history shift made by a lookup and the repair written by a resolved update can land on the same entry in the same clock. The bench provokes this by holding a lookup of a line and a hitting update of the branch in that line on the same cycle. The lookup must still report the pre-edge history and direction. The next lookup must show the history the update wrote, not the shifted value. A second overlap is a lower-offset not-taken conditional sharing a line with a taken jump. There the order and discard rules decide which way is reported and which histories move.

// File: rtl/btb_pkg.sv
// Shared constants and the branch kind encoding of the branch target buffer.
// Assumes 32-bit fetch addresses and 16-byte fetch lines.
package btb_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 4;

    typedef enum logic [1:0] {
        BR_COND = 2'b00,
        BR_RET  = 2'b01,
        BR_CALL = 2'b10,
        BR_JUMP = 2'b11
    } br_kind_e;
endpackage

// File: rtl/btb_pick.sv
// Orders the ways of one set by branch offset and chooses the reported way.
// Input cand marks ways that are valid, tag-matched and at or after the fetch offset.
// Input tk marks ways predicted taken. Ties in offset go to the lower way index.
// shift_mask marks the candidates whose history moves this lookup.
module btb_pick #(
    parameter int WAYS  = 4,
    parameter int OFF_W = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]       cand,
    input  logic [WAYS-1:0]       tk,
    input  logic [WAYS*OFF_W-1:0] offs,
    output logic                  any_cand,
    output logic                  any_tk,
    output logic [WAY_W-1:0]      sel_way,
    output logic [WAYS-1:0]       shift_mask
);
    logic [OFF_W-1:0] c_off, t_off, lim_off;
    logic [WAY_W-1:0] c_way, t_way;

    // Find the lowest-offset candidate and the lowest-offset taken candidate.
    always_comb begin
        any_cand = 1'b0;
        any_tk   = 1'b0;
        c_off    = '1;
        t_off    = '1;
        c_way    = '0;
        t_way    = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (cand[w] && (!any_cand || offs[w*OFF_W +: OFF_W] < c_off)) begin
                any_cand = 1'b1;
                c_off    = offs[w*OFF_W +: OFF_W];
                c_way    = WAY_W'(w);
            end
            if (cand[w] && tk[w] && (!any_tk || offs[w*OFF_W +: OFF_W] < t_off)) begin
                any_tk = 1'b1;
                t_off  = offs[w*OFF_W +: OFF_W];
                t_way  = WAY_W'(w);
            end
        end
    end

    // Report the first taken way, or the first candidate when none is taken.
    always_comb begin
        sel_way = any_tk ? t_way : c_way;
        lim_off = any_tk ? t_off : '1;
    end

    // Candidates up to the reported taken branch advance their history.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            shift_mask[w] = cand[w] && (offs[w*OFF_W +: OFF_W] <= lim_off);
        end
    end
endmodule

// File: rtl/btb_rstack.sv
// Circular return address stack: push on predicted calls, pop on predicted returns.
// Assumes DEPTH is a power of two so the pointer wraps on its own; overflow
// overwrites the oldest slot and underflow reads whatever that slot holds.
module btb_rstack #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    output logic [AW-1:0] top_addr,
    output logic [PW-1:0] ptr
);
    logic [AW-1:0] slot [DEPTH];

    // Write the pushed address and move the pointer; push has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else if (push) begin
            slot[ptr] <= push_addr;
            ptr       <= ptr + PW'(1);
        end else if (pop) begin
            ptr <= ptr - PW'(1);
        end
    end

    // The top of stack is the slot just below the pointer.
    always_comb top_addr = slot[ptr - PW'(1)];
endmodule

// File: rtl/branch_target_buffer.sv
// Set-associative branch target buffer with local histories and per-set counters.
// A lookup is combinational from lk_addr against state updated on the clock edge.
// Resolution updates override speculative history writes to the same entry.
// Assumes WAYS and RAS_DEPTH are powers of two. Tag, offset, kind and target
// payload carry no reset because the valid bits guard them.
module branch_target_buffer
    import btb_pkg::*;
#(
    parameter int SETS      = 128,
    parameter int WAYS      = 4,
    parameter int HIST_W    = 4,
    parameter int RAS_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              pr_hit,
    output logic              pr_taken,
    output logic [1:0]        pr_kind,
    output logic [OFF_W-1:0]  pr_off,
    output logic [ADDR_W-1:0] pr_target,
    output logic [ADDR_W-1:0] pr_next,
    output logic [HIST_W-1:0] pr_hist,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              up_taken,
    input  logic [1:0]        up_kind,
    input  logic [ADDR_W-1:0] up_target,
    input  logic [HIST_W-1:0] up_hist
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int CTRS  = 2 ** HIST_W;
    localparam int RAS_W = $clog2(RAS_DEPTH);

    // Entry state.
    logic              ent_v    [SETS][WAYS];
    logic [HIST_W-1:0] ent_hist [SETS][WAYS];
    logic [TAG_W-1:0]  ent_tag  [SETS][WAYS];
    logic [OFF_W-1:0]  ent_off  [SETS][WAYS];
    br_kind_e          ent_kind [SETS][WAYS];
    logic [ADDR_W-1:0] ent_tgt  [SETS][WAYS];
    logic [1:0]        ctr      [SETS][CTRS];
    logic [WAY_W-1:0]  rr_ptr   [SETS];

    // Address fields.
    logic [OFF_W-1:0] lk_off, up_off;
    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    assign lk_off = lk_addr[OFF_W-1:0];
    assign lk_idx = lk_addr[OFF_W +: IDX_W];
    assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
    assign up_off = up_addr[OFF_W-1:0];
    assign up_idx = up_addr[OFF_W +: IDX_W];
    assign up_tag = up_addr[ADDR_W-1 -: TAG_W];

    // Per-way read and compare.
    logic [WAYS-1:0]       cand, tk, um;
    logic [WAYS*OFF_W-1:0] offs;
    logic [HIST_W-1:0]     rd_hist [WAYS];
    br_kind_e              rd_kind [WAYS];
    logic [ADDR_W-1:0]     rd_tgt  [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        // Candidate, direction and update-match decisions for one way.
        always_comb begin
            rd_hist[w] = ent_hist[lk_idx][w];
            rd_kind[w] = ent_kind[lk_idx][w];
            rd_tgt[w]  = ent_tgt[lk_idx][w];
            offs[w*OFF_W +: OFF_W] = ent_off[lk_idx][w];
            cand[w] = ent_v[lk_idx][w] && (ent_tag[lk_idx][w] == lk_tag)
                      && (ent_off[lk_idx][w] >= lk_off);
            tk[w]   = (rd_kind[w] != BR_COND) || ctr[lk_idx][rd_hist[w]][1];
            um[w]   = ent_v[up_idx][w] && (ent_tag[up_idx][w] == up_tag)
                      && (ent_off[up_idx][w] == up_off);
        end
    end

    // Offset ordering and way choice.
    logic             any_cand, any_tk;
    logic [WAY_W-1:0] sel_way;
    logic [WAYS-1:0]  shift_mask;

    btb_pick #(.WAYS(WAYS), .OFF_W(OFF_W)) i_pick (
        .cand(cand), .tk(tk), .offs(offs),
        .any_cand(any_cand), .any_tk(any_tk),
        .sel_way(sel_way), .shift_mask(shift_mask)
    );

    // Return stack.
    logic              ras_push, ras_pop;
    logic [ADDR_W-1:0] ras_top, seq_next;
    logic [RAS_W-1:0]  ras_ptr;

    btb_rstack #(.DEPTH(RAS_DEPTH), .AW(ADDR_W)) i_rstack (
        .clk(clk), .rst_n(rst_n), .push(ras_push), .pop(ras_pop),
        .push_addr(seq_next), .top_addr(ras_top), .ptr(ras_ptr)
    );

    // Prediction outputs and the next fetch address.
    always_comb begin
        seq_next  = {lk_addr[ADDR_W-1:OFF_W] + (ADDR_W-OFF_W)'(1), {OFF_W{1'b0}}};
        pr_hit    = lk_valid && any_cand;
        pr_taken  = lk_valid && any_tk;
        pr_kind   = rd_kind[sel_way];
        pr_off    = offs[sel_way*OFF_W +: OFF_W];
        pr_hist   = rd_hist[sel_way];
        pr_target = (rd_kind[sel_way] == BR_RET) ? ras_top : rd_tgt[sel_way];
        pr_next   = pr_taken ? pr_target : seq_next;
        ras_push  = pr_taken && (rd_kind[sel_way] == BR_CALL);
        ras_pop   = pr_taken && (rd_kind[sel_way] == BR_RET);
    end

    // Update-side way selection, victim choice and counter training value.
    logic             up_hit, alloc;
    logic [WAY_W-1:0] up_way, victim;
    logic [1:0]       ctr_cur, ctr_nxt;

    always_comb begin
        up_hit = |um;
        up_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (um[w]) up_way = WAY_W'(w);
        end
        victim  = rr_ptr[up_idx];
        alloc   = up_valid && !up_hit && up_taken;
        ctr_cur = ctr[up_idx][up_hist];
        if (up_taken) ctr_nxt = (ctr_cur == 2'b11) ? 2'b11 : ctr_cur + 2'd1;
        else          ctr_nxt = (ctr_cur == 2'b00) ? 2'b00 : ctr_cur - 2'd1;
    end

    // Valid bits, histories, counters and replacement pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rr_ptr[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    ent_v[s][w]    <= 1'b0;
                    ent_hist[s][w] <= '0;
                end
                for (int c = 0; c < CTRS; c++) ctr[s][c] <= 2'b01;
            end
        end else begin
            if (lk_valid) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (shift_mask[w])
                        ent_hist[lk_idx][w] <= {rd_hist[w][HIST_W-2:0], tk[w]};
                end
            end
            if (up_valid && up_hit) begin
                ent_hist[up_idx][up_way] <= {up_hist[HIST_W-2:0], up_taken};
                ctr[up_idx][up_hist]     <= ctr_nxt;
            end
            if (alloc) begin
                ent_v[up_idx][victim]    <= 1'b1;
                ent_hist[up_idx][victim] <= HIST_W'(1);
                rr_ptr[up_idx]           <= victim + WAY_W'(1);
            end
        end
    end

    // Entry payload: written on allocation, target refreshed on taken hits.
    always_ff @(posedge clk) begin
        if (alloc) begin
            ent_tag[up_idx][victim]  <= up_tag;
            ent_off[up_idx][victim]  <= up_off;
            ent_kind[up_idx][victim] <= br_kind_e'(up_kind);
            ent_tgt[up_idx][victim]  <= up_target;
        end else if (up_valid && up_hit && up_taken) begin
            ent_tgt[up_idx][up_way] <= up_target;
        end
    end
endmodule

// File: rtl/btb_checker.sv
// Protocol checker for the branch target buffer: relates the lookup address,
// the reported branch, the next fetch address and the return stack pointer.
module btb_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int RAS_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              pr_hit,
    input logic              pr_taken,
    input logic [1:0]        pr_kind,
    input logic [OFF_W-1:0]  pr_off,
    input logic [ADDR_W-1:0] pr_target,
    input logic [ADDR_W-1:0] pr_next,
    input logic [RAS_W-1:0]  ras_ptr
);
    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pr_taken |-> pr_hit); // R4
    AST_NONCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_hit && pr_kind != 2'b00) |-> pr_taken); // R5
    AST_OFFSET_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        pr_hit |-> (pr_off >= lk_addr[OFF_W-1:0])); // R3
    AST_TAKEN_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        pr_taken |-> (pr_next == pr_target)); // R7
    AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !pr_taken) |->
        (pr_next == {lk_addr[ADDR_W-1:OFF_W] + (ADDR_W-OFF_W)'(1), {OFF_W{1'b0}}})); // R7
    AST_RAS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_taken && pr_kind == 2'b10) |=> (ras_ptr == RAS_W'($past(ras_ptr) + 1'b1))); // R11
    AST_RAS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_taken && pr_kind == 2'b01) |=> (ras_ptr == RAS_W'($past(ras_ptr) - 1'b1))); // R11
endmodule

bind branch_target_buffer btb_checker #(
    .ADDR_W(btb_pkg::ADDR_W), .OFF_W(btb_pkg::OFF_W), .RAS_W(RAS_W)
) i_btb_checker (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .pr_hit(pr_hit), .pr_taken(pr_taken), .pr_kind(pr_kind), .pr_off(pr_off),
    .pr_target(pr_target), .pr_next(pr_next), .ras_ptr(ras_ptr)
);

// File: tb/test_branch_target_buffer.sv
// Scoreboard bench: driver tasks queue the expected prediction for each lookup,
// and a monitor pops and compares it late in the same cycle.
module test_branch_target_buffer;
    logic        clk, rst_n;
    logic        lk_valid, up_valid, up_taken;
    logic [31:0] lk_addr, up_addr, up_target;
    logic [1:0]  up_kind;
    logic [3:0]  up_hist;
    logic        pr_hit, pr_taken;
    logic [1:0]  pr_kind;
    logic [3:0]  pr_off, pr_hist;
    logic [31:0] pr_target, pr_next;

    branch_target_buffer i_branch_target_buffer (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .pr_hit(pr_hit), .pr_taken(pr_taken), .pr_kind(pr_kind), .pr_off(pr_off),
        .pr_target(pr_target), .pr_next(pr_next), .pr_hist(pr_hist),
        .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken),
        .up_kind(up_kind), .up_target(up_target), .up_hist(up_hist)
    );

    typedef struct {
        logic        hit;
        logic        taken;
        logic [1:0]  kind;
        logic [3:0]  off;
        logic [31:0] target;
        logic [31:0] next;
        logic [3:0]  hist;
        bit          chk_hist;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    int   vectors = 0;
    int   fails   = 0;
    bit   done    = 0;

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // One driven cycle: optional lookup with its expectation, optional update.
    task automatic drive(input bit do_lk, input logic [31:0] a, input exp_t e,
                         input bit do_up, input logic [31:0] ua, input logic ut,
                         input logic [1:0] uk, input logic [31:0] utg, input logic [3:0] uh);
        @(negedge clk);
        lk_valid = do_lk; lk_addr = a;
        up_valid = do_up; up_addr = ua; up_taken = ut;
        up_kind = uk; up_target = utg; up_hist = uh;
        if (do_lk) sb_q.push_back(e);
        @(posedge clk);
        #1;
        lk_valid = 1'b0;
        up_valid = 1'b0;
    endtask

    function automatic exp_t mk(input logic h, input logic t, input logic [1:0] k,
                                input logic [3:0] o, input logic [31:0] tg,
                                input logic [31:0] n, input logic [3:0] hi,
                                input bit ch, input string r);
        exp_t e;
        e.hit = h; e.taken = t; e.kind = k; e.off = o; e.target = tg;
        e.next = n; e.hist = hi; e.chk_hist = ch; e.req = r;
        return e;
    endfunction

    task automatic lk_miss(input logic [31:0] a, input string r);
        drive(1'b1, a, mk(1'b0, 1'b0, 2'd0, 4'd0, 32'd0,
                          {a[31:4] + 28'd1, 4'd0}, 4'd0, 1'b0, r),
              1'b0, 32'd0, 1'b0, 2'd0, 32'd0, 4'd0);
    endtask

    task automatic lk_hit(input logic [31:0] a, input logic t, input logic [1:0] k,
                          input logic [3:0] o, input logic [31:0] tg,
                          input logic [31:0] n, input logic [3:0] hi,
                          input bit ch, input string r);
        drive(1'b1, a, mk(1'b1, t, k, o, tg, n, hi, ch, r),
              1'b0, 32'd0, 1'b0, 2'd0, 32'd0, 4'd0);
    endtask

    task automatic upd(input logic [31:0] ua, input logic ut, input logic [1:0] uk,
                       input logic [31:0] utg, input logic [3:0] uh);
        exp_t none;
        none = mk(1'b0, 1'b0, 2'd0, 4'd0, 32'd0, 32'd0, 4'd0, 1'b0, "");
        drive(1'b0, 32'd0, none, 1'b1, ua, ut, uk, utg, uh);
    endtask

    // Monitor: compare the queued expectation just before the next rising edge.
    initial begin
        exp_t e;
        bit   ok;
        forever begin
            @(negedge clk);
            #3;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                vectors++;
                if (!e.hit)
                    ok = (pr_hit === 1'b0) && (pr_taken === 1'b0) && (pr_next === e.next);
                else
                    ok = (pr_hit === 1'b1) && (pr_taken === e.taken) && (pr_kind === e.kind)
                         && (pr_off === e.off) && (pr_target === e.target)
                         && (pr_next === e.next) && (!e.chk_hist || pr_hist === e.hist);
                if (!ok) begin
                    fails++;
                    $display("FAIL %s: got hit=%0b taken=%0b kind=%0d off=%0d tgt=%h next=%h hist=%b, expected hit=%0b taken=%0b kind=%0d off=%0d tgt=%h next=%h hist=%b",
                             e.req, pr_hit, pr_taken, pr_kind, pr_off, pr_target, pr_next, pr_hist,
                             e.hit, e.taken, e.kind, e.off, e.target, e.next, e.hist);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1: got run still active, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; lk_valid = 1'b0; up_valid = 1'b0; lk_addr = '0; up_addr = '0;
        up_taken = 1'b0; up_kind = '0; up_target = '0; up_hist = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset
        lk_miss(32'h0000_1230, "R1");
        lk_miss(32'h0000_2000, "R1");

        // Set 0x23: ordering, discard, counters
        upd(32'h1234, 1'b1, 2'd3, 32'h8000, 4'h0);
        lk_hit(32'h1230, 1'b1, 2'd3, 4'd4, 32'h8000, 32'h8000, 4'h0, 1'b0, "R5 jump taken");
        lk_miss(32'h3230, "R2 tag mismatch");
        lk_miss(32'h1235, "R3 offset below fetch");
        upd(32'h1232, 1'b1, 2'd0, 32'h9000, 4'h0);
        lk_hit(32'h1230, 1'b1, 2'd3, 4'd4, 32'h8000, 32'h8000, 4'h0, 1'b0, "R4 skip not-taken");
        upd(32'h1232, 1'b1, 2'd0, 32'h9000, 4'hF);
        lk_hit(32'h1230, 1'b1, 2'd0, 4'd2, 32'h9000, 32'h9000, 4'hF, 1'b1, "R6 counter taken");
        upd(32'h1232, 1'b0, 2'd0, 32'h9000, 4'hF);
        upd(32'h1232, 1'b0, 2'd0, 32'h9000, 4'hF);
        lk_hit(32'h1230, 1'b1, 2'd3, 4'd4, 32'h8000, 32'h8000, 4'h0, 1'b0, "R6 counter fell");
        upd(32'h1232, 1'b0, 2'd0, 32'h9000, 4'hF);
        upd(32'h1232, 1'b1, 2'd0, 32'h9000, 4'hF);
        lk_hit(32'h1230, 1'b1, 2'd3, 4'd4, 32'h8000, 32'h8000, 4'h0, 1'b0, "R6 low saturation");

        // R10: replacement pointer
        upd(32'h1A36, 1'b1, 2'd3, 32'hA000, 4'h0);
        upd(32'h2236, 1'b1, 2'd3, 32'hB000, 4'h0);
        lk_hit(32'h1233, 1'b1, 2'd3, 4'd4, 32'h8000, 32'h8000, 4'h0, 1'b0, "R10 before evict");
        upd(32'h2A36, 1'b1, 2'd3, 32'hC000, 4'h0);
        lk_miss(32'h1233, "R10 evicted");
        lk_hit(32'h2A30, 1'b1, 2'd3, 4'd6, 32'hC000, 32'hC000, 4'h0, 1'b0, "R10 new way");
        lk_hit(32'h1A30, 1'b1, 2'd3, 4'd6, 32'hA000, 32'hA000, 4'h0, 1'b0, "R10 kept way");
        lk_hit(32'h1230, 1'b0, 2'd0, 4'd2, 32'h9000, 32'h1240, 4'hE, 1'b1, "R4 none taken");

        // Set 0: speculative history, repair, same-cycle overlap
        upd(32'h2008, 1'b1, 2'd0, 32'h7000, 4'h0);
        lk_hit(32'h2000, 1'b0, 2'd0, 4'd8, 32'h7000, 32'h2010, 4'b0001, 1'b1, "R8 first");
        lk_hit(32'h2000, 1'b0, 2'd0, 4'd8, 32'h7000, 32'h2010, 4'b0010, 1'b1, "R8 shifted");
        upd(32'h2008, 1'b1, 2'd0, 32'h7000, 4'b0001);
        lk_hit(32'h2000, 1'b0, 2'd0, 4'd8, 32'h7000, 32'h2010, 4'b0011, 1'b1, "R9 repair");
        drive(1'b1, 32'h2000,
              mk(1'b1, 1'b0, 2'd0, 4'd8, 32'h7000, 32'h2010, 4'b0110, 1'b1, "R9 same cycle"),
              1'b1, 32'h2008, 1'b1, 2'd0, 32'h7770, 4'b0110);
        lk_hit(32'h2000, 1'b0, 2'd0, 4'd8, 32'h7770, 32'h2010, 4'b1101, 1'b1, "R9 update wins");
        lk_miss(32'h2009, "R3 one past");
        upd(32'h4004, 1'b0, 2'd0, 32'h1111, 4'h0);
        lk_miss(32'h4000, "R10 not-taken miss ignored");

        // R11: return stack
        upd(32'h3004, 1'b1, 2'd2, 32'h5000, 4'h0);
        upd(32'h5108, 1'b1, 2'd1, 32'hDEAD_0000, 4'h0);
        upd(32'h60A0, 1'b1, 2'd2, 32'h5000, 4'h0);
        lk_hit(32'h3000, 1'b1, 2'd2, 4'd4, 32'h5000, 32'h5000, 4'h0, 1'b0, "R11 call");
        lk_hit(32'h60A0, 1'b1, 2'd2, 4'd0, 32'h5000, 32'h5000, 4'h0, 1'b0, "R11 call");
        lk_hit(32'h5100, 1'b1, 2'd1, 4'd8, 32'h60B0, 32'h60B0, 4'h0, 1'b0, "R11 newest");
        lk_hit(32'h5100, 1'b1, 2'd1, 4'd8, 32'h3010, 32'h3010, 4'h0, 1'b0, "R11 older");
        lk_hit(32'h60A0, 1'b1, 2'd2, 4'd0, 32'h5000, 32'h5000, 4'h0, 1'b0, "R11 call");
        for (int i = 0; i < 8; i++)
            lk_hit(32'h3000, 1'b1, 2'd2, 4'd4, 32'h5000, 32'h5000, 4'h0, 1'b0, "R11 fill");
        for (int i = 0; i < 9; i++)
            lk_hit(32'h5100, 1'b1, 2'd1, 4'd8, 32'h3010, 32'h3010, 4'h0, 1'b0, "R11 wrap");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule